// File: doc/BRIEF.md
# 64-bit SEC-DED Error Check Codec

This block protects a 64-bit data word with an 8-bit check byte drawn from a fixed parity matrix. A purely combinational encoder turns a data word into its check byte for the write path. A registered checker takes a received data word and its stored check byte, forms the syndrome and sorts the result into four classes: clean, single data-bit fault, single check-bit fault, or uncorrectable. For the first three classes it reports the faulty bit position and hands out the repaired data word.

The checker accepts one word per cycle under a valid strobe and presents the syndrome, class, bit index and repaired data one clock later, together with an output valid flag. The fields keep their values in cycles with no strobe. The parity matrix is fixed. Each of the eight check bits is the parity of the data bits picked by one 64-bit mask. The column of a data bit is the 8-bit pattern that bit leaves across the eight masks. A single data-bit fault is found by matching the syndrome against these columns.

Top module: `secded64_codec`

## Requirements
- R1: `enc_check_o[i]` is the XOR of the data bits selected by mask i. Written as high word : low word, where the high word selects data bits 63:32 and the low word bits 31:0, the masks for i = 0..7 are F00FE11E:C33C0FF7, 00FF00FF:00FFF0FF, 0F0F0F0F:0F0FFF00, 11113333:7777000F, 22224444:8888222F, 44448888:FFFF4441, 8888FFFF:11118882, FFFF1111:22221114.
- R2: `syndrome_o` is the R1 check byte of `chk_data_i` XOR `chk_ecc_i`, as captured under the strobe.
- R3: A zero syndrome gives class 0 (clean), bit index 0 and `corr_data_o` equal to the received data.
- R4: If the syndrome equals the column of data bit b (bit i of the column = bit b of mask i), the class is 1 (data fault) and the index is b. When several columns match, the lowest b wins, and data columns are tried before any check-bit decision.
- R5: On class 1, `corr_data_o` is the received data with bit b inverted, and all other bits equal.
- R6: If no column matches and the syndrome has exactly one bit set, the class is 2 (check-bit fault), the index is the position of that bit, and the data passes unchanged.
- R7: Any other nonzero syndrome gives class 3 (uncorrectable), index 0 and the data unchanged.
- R8: `out_valid_o` follows `chk_valid_i` one clock later. The result fields update only on cycles with the strobe and otherwise hold their values.
- R9: While `rst_n` is low, every registered output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_data_i | input | 64 | Word to encode |
| enc_check_o | output | 8 | Check byte for `enc_data_i` (combinational) |
| chk_valid_i | input | 1 | Strobe for a received word |
| chk_data_i | input | 64 | Received data word |
| chk_ecc_i | input | 8 | Received check byte |
| out_valid_o | output | 1 | Result valid, one clock after the strobe |
| syndrome_o | output | 8 | Captured syndrome |
| err_class_o | output | 2 | 0 clean, 1 data fault, 2 check fault, 3 uncorrectable |
| bad_bit_o | output | 6 | Faulty bit index (data 0..63 or check 0..7) |
| corr_data_o | output | 64 | Repaired data word |

## Verification
A wrong column value, or a wrong priority between columns, shows up on the first strobed word whose syndrome involves that column. It appears one clock later as a wrong class or index and as a repaired word that differs from the input in a position other than the one flipped. A wrong mask bit corrupts the combinational encoder output in the same cycle, and the captured syndrome one clock later. A stale or early capture register shows as a result that belongs to the wrong strobe, or as fields that change during idle cycles. The bench walks every single data and check flip, double flips and random words, so each column is used at least once.

// File: rtl/secded64_pkg.sv
package secded64_pkg;
  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;
  localparam int IDX_W  = $clog2(DATA_W);

  typedef enum logic [1:0] {
    CLS_CLEAN = 2'd0,
    CLS_DATA  = 2'd1,
    CLS_CHECK = 2'd2,
    CLS_FATAL = 2'd3
  } err_class_e;

  // Parity selection mask for check bit i (high word covers data 63:32)
  function automatic logic [DATA_W-1:0] mask_row(input int unsigned i);
    case (i)
      0: return 64'hF00FE11E_C33C0FF7;
      1: return 64'h00FF00FF_00FFF0FF;
      2: return 64'h0F0F0F0F_0F0FFF00;
      3: return 64'h11113333_7777000F;
      4: return 64'h22224444_8888222F;
      5: return 64'h44448888_FFFF4441;
      6: return 64'h8888FFFF_11118882;
      7: return 64'hFFFF1111_22221114;
      default: return '0;
    endcase
  endfunction

  function automatic logic [CHK_W-1:0] check_of(input logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] c;
    for (int i = 0; i < CHK_W; i++) c[i] = ^(d & mask_row(i));
    return c;
  endfunction

  // Syndrome produced by a flip of data bit b
  function automatic logic [CHK_W-1:0] column_of(input int unsigned b);
    logic [CHK_W-1:0] c;
    logic [DATA_W-1:0] m;
    for (int i = 0; i < CHK_W; i++) begin
      m    = mask_row(i);
      c[i] = m[b];
    end
    return c;
  endfunction
endpackage

// File: rtl/secded64_encoder.sv
module secded64_encoder
  import secded64_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  check_o
);
  assign check_o = check_of(data_i);
endmodule

// File: rtl/secded64_locator.sv
module secded64_locator
  import secded64_pkg::*;
(
  input  logic [CHK_W-1:0] syndrome_i,
  output err_class_e       class_o,
  output logic [IDX_W-1:0] index_o
);
  logic [DATA_W-1:0] col_hit;
  logic [IDX_W-1:0]  data_idx;
  logic [IDX_W-1:0]  chk_idx;
  logic              any_col;
  logic              single_bit;

  for (genvar b = 0; b < DATA_W; b++) begin : g_col
    assign col_hit[b] = (syndrome_i == column_of(b));
  end

  assign any_col    = |col_hit;
  assign single_bit = ($countones(syndrome_i) == 1);

  // Lowest matching column wins: scan downward, last hit assigned is lowest
  always_comb begin
    data_idx = '0;
    for (int b = DATA_W - 1; b >= 0; b--)
      if (col_hit[b]) data_idx = IDX_W'(b);
  end

  always_comb begin
    chk_idx = '0;
    for (int i = CHK_W - 1; i >= 0; i--)
      if (syndrome_i[i]) chk_idx = IDX_W'(i);
  end

  always_comb begin
    if (syndrome_i == '0) begin
      class_o = CLS_CLEAN;
      index_o = '0;
    end else if (any_col) begin
      class_o = CLS_DATA;
      index_o = data_idx;
    end else if (single_bit) begin
      class_o = CLS_CHECK;
      index_o = chk_idx;
    end else begin
      class_o = CLS_FATAL;
      index_o = '0;
    end
  end
endmodule

// File: rtl/secded64_fixer.sv
module secded64_fixer
  import secded64_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  err_class_e        class_i,
  input  logic [IDX_W-1:0]  index_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] flip_mask;
  assign flip_mask = (class_i == CLS_DATA) ? (DATA_W'(1) << index_i) : '0;
  assign data_o    = data_i ^ flip_mask;
endmodule

// File: rtl/secded64_codec.sv
module secded64_codec
  import secded64_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] enc_data_i,
  output logic [CHK_W-1:0]  enc_check_o,
  input  logic              chk_valid_i,
  input  logic [DATA_W-1:0] chk_data_i,
  input  logic [CHK_W-1:0]  chk_ecc_i,
  output logic              out_valid_o,
  output logic [CHK_W-1:0]  syndrome_o,
  output logic [1:0]        err_class_o,
  output logic [IDX_W-1:0]  bad_bit_o,
  output logic [DATA_W-1:0] corr_data_o
);
  logic [CHK_W-1:0]  recomputed;
  logic [CHK_W-1:0]  syn_c;
  err_class_e        cls_c;
  logic [IDX_W-1:0]  idx_c;
  logic [DATA_W-1:0] fix_c;
  err_class_e        cls_q;

  secded64_encoder u_enc_wr (.data_i(enc_data_i), .check_o(enc_check_o));
  secded64_encoder u_enc_rd (.data_i(chk_data_i), .check_o(recomputed));

  assign syn_c = recomputed ^ chk_ecc_i;

  secded64_locator u_loc (.syndrome_i(syn_c), .class_o(cls_c), .index_o(idx_c));

  secded64_fixer u_fix (
    .data_i(chk_data_i), .class_i(cls_c), .index_i(idx_c), .data_o(fix_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      syndrome_o  <= '0;
      cls_q       <= CLS_CLEAN;
      bad_bit_o   <= '0;
      corr_data_o <= '0;
    end else begin
      out_valid_o <= chk_valid_i;
      if (chk_valid_i) begin
        syndrome_o  <= syn_c;
        cls_q       <= cls_c;
        bad_bit_o   <= idx_c;
        corr_data_o <= fix_c;
      end
    end
  end

  assign err_class_o = cls_q;
endmodule

// File: rtl/secded64_codec_chk.sv
module secded64_codec_chk
  import secded64_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              chk_valid_i,
  input logic [DATA_W-1:0] chk_data_i,
  input logic              out_valid_o,
  input logic [CHK_W-1:0]  syndrome_o,
  input logic [1:0]        err_class_o,
  input logic [IDX_W-1:0]  bad_bit_o,
  input logic [DATA_W-1:0] corr_data_o
);
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid_i |=> out_valid_o); // R8
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid_i |=> !out_valid_o); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid_i |=> ($stable(syndrome_o) && $stable(corr_data_o) && $stable(bad_bit_o))); // R8
  AST_CLEAN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && syndrome_o == '0) |-> (err_class_o == 2'd0 && bad_bit_o == '0)); // R3
  AST_CHECK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && err_class_o == 2'd2) |-> ($countones(syndrome_o) == 1)); // R6
  AST_DATA_ONE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && err_class_o == 2'd1) |-> ($countones(corr_data_o ^ $past(chk_data_i)) == 1)); // R5
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && err_class_o != 2'd1) |-> (corr_data_o == $past(chk_data_i))); // R7
  AST_FATAL_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && err_class_o == 2'd3) |-> (bad_bit_o == '0 && syndrome_o != '0)); // R7
endmodule

bind secded64_codec secded64_codec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .chk_valid_i(chk_valid_i), .chk_data_i(chk_data_i),
  .out_valid_o(out_valid_o), .syndrome_o(syndrome_o), .err_class_o(err_class_o),
  .bad_bit_o(bad_bit_o), .corr_data_o(corr_data_o)
);

// File: tb/sim_secded64_codec.sv
`timescale 1ns/1ps
module sim_secded64_codec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] enc_data_i = '0;
  logic [7:0]  enc_check_o;
  logic        chk_valid_i = 1'b0;
  logic [63:0] chk_data_i = '0;
  logic [7:0]  chk_ecc_i = '0;
  logic        out_valid_o;
  logic [7:0]  syndrome_o;
  logic [1:0]  err_class_o;
  logic [5:0]  bad_bit_o;
  logic [63:0] corr_data_o;

  int n_cmp = 0;
  int n_bad = 0;

  // Masks from R1, written independently of the design
  logic [63:0] mtab [8];
  initial begin
    mtab[0] = {32'hF00FE11E, 32'hC33C0FF7};
    mtab[1] = {32'h00FF00FF, 32'h00FFF0FF};
    mtab[2] = {32'h0F0F0F0F, 32'h0F0FFF00};
    mtab[3] = {32'h11113333, 32'h7777000F};
    mtab[4] = {32'h22224444, 32'h8888222F};
    mtab[5] = {32'h44448888, 32'hFFFF4441};
    mtab[6] = {32'h8888FFFF, 32'h11118882};
    mtab[7] = {32'hFFFF1111, 32'h22221114};
  end

  // expected (model) state
  logic        e_valid;
  logic [7:0]  e_syn;
  int          e_cls;
  int          e_idx;
  logic [63:0] e_data;

  always #4 clk = ~clk;

  secded64_codec u0 (
    .clk(clk), .rst_n(rst_n), .enc_data_i(enc_data_i), .enc_check_o(enc_check_o),
    .chk_valid_i(chk_valid_i), .chk_data_i(chk_data_i), .chk_ecc_i(chk_ecc_i),
    .out_valid_o(out_valid_o), .syndrome_o(syndrome_o), .err_class_o(err_class_o),
    .bad_bit_o(bad_bit_o), .corr_data_o(corr_data_o)
  );

  function automatic logic [7:0] ref_check(input logic [63:0] d);
    logic [7:0] c = '0;
    for (int i = 0; i < 8; i++) begin
      int p = 0;
      for (int j = 0; j < 64; j++)
        if (mtab[i][j] && d[j]) p = p ^ 1;
      c[i] = p[0];
    end
    return c;
  endfunction

  task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string cls_tag(input int c);
    case (c)
      0: return "R3 class";
      1: return "R4 class";
      2: return "R6 class";
      default: return "R7 class";
    endcase
  endfunction

  task automatic model_capture(input logic [63:0] d, input logic [7:0] e);
    logic [7:0] col;
    int hit = -1;
    e_syn  = ref_check(d) ^ e;
    e_data = d;
    if (e_syn == 8'h00) begin
      e_cls = 0; e_idx = 0;
    end else begin
      for (int b = 0; b < 64; b++) begin
        for (int i = 0; i < 8; i++) col[i] = mtab[i][b];
        if (hit < 0 && col == e_syn) hit = b;
      end
      if (hit >= 0) begin
        e_cls = 1; e_idx = hit; e_data[hit] = ~d[hit];
      end else if ($countones(e_syn) == 1) begin
        e_cls = 2; e_idx = 0;
        for (int i = 7; i >= 0; i--) if (e_syn[i]) e_idx = i;
      end else begin
        e_cls = 3; e_idx = 0;
      end
    end
  endtask

  task automatic compare_all();
    cmp("R8 valid", 64'(out_valid_o), 64'(e_valid));
    cmp("R2 syndrome", 64'(syndrome_o), 64'(e_syn));
    cmp(cls_tag(e_cls), 64'(err_class_o), 64'(e_cls));
    cmp(e_cls == 2 ? "R6 index" : "R4 index", 64'(bad_bit_o), 64'(e_idx));
    cmp(e_cls == 1 ? "R5 data" : "R7 data", corr_data_o, e_data);
  endtask

  // drive at negedge, compare one clock later at the next negedge
  task automatic step(input logic v, input logic [63:0] d, input logic [7:0] e);
    chk_valid_i = v;
    chk_data_i  = d;
    chk_ecc_i   = e;
    enc_data_i  = d;
    #1;
    cmp("R1 encode", 64'(enc_check_o), 64'(ref_check(d)));
    if (v) model_capture(d, e);
    e_valid = v;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] d;
    e_valid = 0; e_syn = 0; e_cls = 0; e_idx = 0; e_data = 0;
    @(negedge clk);
    @(negedge clk);
    // R9: reset state
    cmp("R9 valid", 64'(out_valid_o), 64'd0);
    cmp("R9 syndrome", 64'(syndrome_o), 64'd0);
    cmp("R9 class", 64'(err_class_o), 64'd0);
    cmp("R9 index", 64'(bad_bit_o), 64'd0);
    cmp("R9 data", corr_data_o, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: clean words, including all-zero and all-one
    step(1'b1, 64'h0, ref_check(64'h0));
    step(1'b1, '1, ref_check('1));
    for (int k = 0; k < 8; k++) begin
      d = {$urandom, $urandom};
      step(1'b1, d, ref_check(d));
    end

    // R4/R5: every single data-bit flip
    for (int b = 0; b < 64; b++) begin
      d = {$urandom, $urandom};
      step(1'b1, d ^ (64'd1 << b), ref_check(d));
    end

    // R6: every single check-bit flip
    for (int i = 0; i < 8; i++) begin
      d = {$urandom, $urandom};
      step(1'b1, d, ref_check(d) ^ (8'd1 << i));
    end

    // R8: idle cycles hold the last result
    step(1'b0, 64'hDEAD_BEEF_0000_1111, 8'h5A);
    step(1'b0, 64'h1234_5678_9ABC_DEF0, 8'hA5);

    // R7: double flips in data, and one data plus one check flip
    for (int k = 0; k < 40; k++) begin
      int b1, b2;
      d  = {$urandom, $urandom};
      b1 = $urandom_range(63, 0);
      b2 = (b1 + 1 + $urandom_range(62, 0)) % 64;
      step(1'b1, d ^ (64'd1 << b1) ^ (64'd1 << b2), ref_check(d));
    end
    for (int k = 0; k < 20; k++) begin
      d = {$urandom, $urandom};
      step(1'b1, d ^ (64'd1 << $urandom_range(63, 0)),
           ref_check(d) ^ (8'd1 << $urandom_range(7, 0)));
    end

    // mixed random words and random strobe pattern
    for (int k = 0; k < 100; k++) begin
      step(1'($urandom_range(1, 0)), {$urandom, $urandom}, 8'($urandom));
    end

    step(1'b0, 64'h0, 8'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule